// File: doc/BRIEF.md
# Microprocessor Bus to Byte-Stream FIFO Bridge

This block lets a microprocessor trade bytes with a streaming back end over an asynchronous 8-bit parallel bus. The bus has an active-low select, one address line and active-low read and write strobes. Inside, a receive FIFO holds bytes on their way to the processor and a transmit FIFO holds bytes the processor has written. The address line chooses between the data pipe and a control/status location.

The bus pins are brought into the clock domain through multi-stage synchronizers. A read strobe is acted on at its falling edge and a write strobe at its rising edge, so each strobe pulse produces exactly one operation however long it lasts. The back end sees two ordinary valid/ready byte streams, a one-cycle flush request, a sticky overflow flag, and supplies suspend and configured levels that are reported in the status byte.

The bus is split into input, output and output-enable, to be joined at a tristate pad. The processor must hold select, address and write data steady for a few clock cycles around each strobe edge.

Top module: `cpubus_fifo_bridge`

## Requirements
- R1: While `cs_n` is high, read and write strobes cause no pop, push or flush, and `bus_oe` stays low.
- R2: `bus_oe` is high exactly while `cs_n` and `rd_n` are both low.
- R3: A read strobe with `a0`=0 removes one byte from the receive FIFO, and the bytes come out on `bus_o` in the order the back end delivered them.
- R4: A read strobe with `a0`=1 returns a status byte with bit 0 = receive data available, bit 1 = transmit FIFO not full, bit 2 = `suspend`, bit 3 = `configured`, bits 7..4 = 0; it removes nothing from either FIFO.
- R5: A write strobe with `a0`=0 stores the byte on `bus_i` into the transmit FIFO, and bytes leave on `tx_out_data` in write order, held stable while `tx_out_valid` is high and `tx_out_ready` low.
- R6: A write strobe with `a0`=1 stores no byte and raises `flush` for exactly one clock cycle.
- R7: A strobe held low for many cycles causes exactly one operation.
- R8: A data read of an empty receive FIFO returns the byte returned by the previous data read and does not advance the read position.
- R9: A data write to a full transmit FIFO is dropped and sets `tx_overflow`, which stays high until reset.
- R10: After reset both FIFOs are empty, `tx_out_valid`, `flush`, `tx_overflow` and `bus_oe` are low and `rx_in_ready` is high.
- R11: `rx_in_ready` is low while the receive FIFO holds 2^AW bytes; a back-end byte is taken when `rx_in_valid` and `rx_in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the processor |
| a0 | input | 1 | 0 = data pipe, 1 = status / flush command |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_i | input | DW | Byte from the processor |
| bus_o | output | DW | Byte to the processor |
| bus_oe | output | 1 | Pad output enable for `bus_o` |
| rx_in_data | input | DW | Back-end byte toward the processor |
| rx_in_valid | input | 1 | `rx_in_data` is valid |
| rx_in_ready | output | 1 | Receive FIFO can take a byte |
| tx_out_data | output | DW | Byte written by the processor |
| tx_out_valid | output | 1 | `tx_out_data` is valid |
| tx_out_ready | input | 1 | Back end takes `tx_out_data` |
| suspend | input | 1 | Suspend level, reported in status |
| configured | input | 1 | Configured level, reported in status |
| flush | output | 1 | One-cycle send-immediate request |
| tx_overflow | output | 1 | Sticky: a write was dropped |

## Verification
The hardest states to reach from the ports are the two FIFO extremes seen through the slow strobe interface: a full transmit FIFO with one more write arriving, and an empty receive FIFO being read after real data went through it. The bench holds `tx_out_ready` low while writing one byte more than the depth, then releases it and lets the scoreboard confirm the dropped byte never appears; it drains the receive side to empty and reads again to check that the last byte repeats and the next delivered byte is not skipped. Long-held strobes are used to confirm one operation per pulse.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  typedef enum logic {SEL_DATA = 1'b0, SEL_STAT = 1'b1} sel_e;

  localparam int ST_RXAV = 0;
  localparam int ST_TXSP = 1;
  localparam int ST_SUSP = 2;
  localparam int ST_CONF = 3;
endpackage

// File: rtl/cbb_sync.sv
module cbb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cbb_fifo.sv
module cbb_fifo #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   level
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cbb_busdec.sv
module cbb_busdec (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic a0_s,
  input  logic rd_n_s,
  input  logic wr_n_s,
  output logic rd_data_ev,
  output logic rd_stat_ev,
  output logic wr_data_ev,
  output logic wr_cmd_ev
);
  import cbb_pkg::*;

  logic rd_prev, wr_prev;
  logic rd_fall, wr_rise;
  sel_e sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b1;
      wr_prev <= 1'b1;
    end else begin
      rd_prev <= rd_n_s;
      wr_prev <= wr_n_s;
    end
  end

  assign sel     = a0_s ? SEL_STAT : SEL_DATA;
  assign rd_fall = rd_prev && !rd_n_s && !cs_n_s;
  assign wr_rise = !wr_prev && wr_n_s && !cs_n_s;

  assign rd_data_ev = rd_fall && (sel == SEL_DATA);
  assign rd_stat_ev = rd_fall && (sel == SEL_STAT);
  assign wr_data_ev = wr_rise && (sel == SEL_DATA);
  assign wr_cmd_ev  = wr_rise && (sel == SEL_STAT);
endmodule

// File: rtl/cpubus_fifo_bridge.sv
module cpubus_fifo_bridge #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          a0,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe,
  input  logic [DW-1:0] rx_in_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  output logic [DW-1:0] tx_out_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  input  logic          suspend,
  input  logic          configured,
  output logic          flush,
  output logic          tx_overflow
);
  import cbb_pkg::*;

  localparam int SW = DW + 4;

  logic [SW-1:0] pins_raw, pins_s;
  logic          cs_n_s, a0_s, rd_n_s, wr_n_s;
  logic [DW-1:0] bus_s;
  logic          rd_data_ev, rd_stat_ev, wr_data_ev, wr_cmd_ev;

  logic [DW-1:0] rx_head, tx_head;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic [AW:0]   rx_level, tx_level;
  logic          rx_push, tx_push, tx_pop;

  logic [DW-1:0] rdata_q, stat_q, stat_now;
  sel_e          sel_q;
  logic          flush_q, ovf_q;

  assign pins_raw = {bus_i, wr_n, rd_n, a0, cs_n};

  cbb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  assign cs_n_s = pins_s[0];
  assign a0_s   = pins_s[1];
  assign rd_n_s = pins_s[2];
  assign wr_n_s = pins_s[3];
  assign bus_s  = pins_s[SW-1:4];

  cbb_busdec u_dec (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .a0_s(a0_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s),
    .rd_data_ev(rd_data_ev), .rd_stat_ev(rd_stat_ev),
    .wr_data_ev(wr_data_ev), .wr_cmd_ev(wr_cmd_ev)
  );

  assign rx_in_ready = !rx_full;
  assign rx_push     = rx_in_valid && !rx_full;

  cbb_fifo #(.W(DW), .AW(AW)) u_rxf (
    .clk(clk), .rst(rst),
    .push(rx_push), .wdata(rx_in_data),
    .pop(rd_data_ev), .head(rx_head),
    .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  assign tx_push = wr_data_ev && !tx_full;
  assign tx_pop  = tx_out_ready && !tx_empty;

  cbb_fifo #(.W(DW), .AW(AW)) u_txf (
    .clk(clk), .rst(rst),
    .push(tx_push), .wdata(bus_s),
    .pop(tx_pop), .head(tx_head),
    .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  assign tx_out_data  = tx_head;
  assign tx_out_valid = !tx_empty;

  always_comb begin
    stat_now          = '0;
    stat_now[ST_RXAV] = !rx_empty;
    stat_now[ST_TXSP] = !tx_full;
    stat_now[ST_SUSP] = suspend;
    stat_now[ST_CONF] = configured;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      stat_q  <= '0;
      sel_q   <= SEL_DATA;
      flush_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (rd_data_ev) begin
        sel_q <= SEL_DATA;
        if (!rx_empty) rdata_q <= rx_head;
      end
      if (rd_stat_ev) begin
        sel_q  <= SEL_STAT;
        stat_q <= stat_now;
      end
      flush_q <= wr_cmd_ev;
      if (wr_data_ev && tx_full) ovf_q <= 1'b1;
    end
  end

  assign bus_o       = (sel_q == SEL_STAT) ? stat_q : rdata_q;
  assign bus_oe      = !cs_n && !rd_n;
  assign flush       = flush_q;
  assign tx_overflow = ovf_q;
endmodule

// File: rtl/cbb_checker.sv
module cbb_checker #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          tx_overflow,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [DW-1:0] tx_out_data,
  input logic          rd_stat_ev,
  input logic          rd_data_ev,
  input logic          rx_push,
  input logic [AW:0]   rx_level
);
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    tx_overflow |=> tx_overflow); // R9

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data))); // R5

  AST_STATUS_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (rd_stat_ev && !rx_push) |=> $stable(rx_level)); // R4

  AST_ONE_POP: assert property (@(posedge clk) disable iff (rst)
    rd_data_ev |=> !rd_data_ev); // R7
endmodule

bind cpubus_fifo_bridge cbb_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .tx_overflow(tx_overflow),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_data(tx_out_data), .rd_stat_ev(rd_stat_ev),
  .rd_data_ev(rd_data_ev), .rx_push(rx_push), .rx_level(rx_level)
);

// File: tb/sim_cpubus_fifo_bridge.sv
`timescale 1ns/1ps
module sim_cpubus_fifo_bridge;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] bus_i = '0;
  logic [DW-1:0] bus_o;
  logic bus_oe;
  logic [DW-1:0] rx_in_data = '0;
  logic rx_in_valid = 1'b0;
  logic rx_in_ready;
  logic [DW-1:0] tx_out_data;
  logic tx_out_valid;
  logic tx_out_ready = 1'b0;
  logic suspend = 1'b0, configured = 1'b0;
  logic flush, tx_overflow;

  int n_chk = 0, n_fail = 0, flush_cnt = 0;
  logic [DW-1:0] exp_tx [$];
  logic [DW-1:0] exp_rx [$];

  always #4 clk = ~clk;

  cpubus_fifo_bridge #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
    .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .suspend(suspend), .configured(configured), .flush(flush), .tx_overflow(tx_overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor on the transmit stream
  always @(negedge clk) begin
    if (!rst) begin
      if (flush) flush_cnt++;
      if (tx_out_valid && tx_out_ready) begin
        if (exp_tx.size() == 0) chk(1'b0, "R5 unexpected byte", tx_out_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_tx.pop_front();
          chk(tx_out_data == e, "R5 stream order", tx_out_data, e);
        end
      end
    end
  end

  task automatic cpu_write(input logic sel, input logic [DW-1:0] d, input bit stored);
    if (stored) exp_tx.push_back(d);
    cs_n = 1'b0; a0 = sel; bus_i = d;
    cyc(2); wr_n = 1'b0;
    cyc(4); wr_n = 1'b1;
    cyc(4); cs_n = 1'b1;
    cyc(3);
  endtask

  task automatic cpu_read(input logic sel, input int hold,
                          output logic [DW-1:0] v, output logic oe);
    cs_n = 1'b0; a0 = sel;
    cyc(2); rd_n = 1'b0;
    cyc(hold);
    @(negedge clk); v = bus_o; oe = bus_oe;
    @(posedge clk); #1; rd_n = 1'b1;
    cyc(3); cs_n = 1'b1;
    cyc(3);
  endtask

  task automatic be_send(input logic [DW-1:0] d);
    logic r;
    exp_rx.push_back(d);
    rx_in_data = d; rx_in_valid = 1'b1;
    forever begin
      @(negedge clk); r = rx_in_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    rx_in_valid = 1'b0;
  endtask

  task automatic read_data_chk(input int hold, input string req);
    logic [DW-1:0] v, e;
    logic oe;
    e = exp_rx.pop_front();
    cpu_read(1'b0, hold, v, oe);
    chk(v == e, req, v, e);
    chk(oe == 1'b1, "R2 drive during read", oe, 1);
  endtask

  task automatic stat_chk(input logic [DW-1:0] e, input string req);
    logic [DW-1:0] v;
    logic oe;
    cpu_read(1'b1, 6, v, oe);
    chk(v == e, req, v, e);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic oe;
    int f0;
    cyc(5); rst = 1'b0; cyc(1);

    @(negedge clk);
    chk(bus_oe == 1'b0, "R10 bus_oe", bus_oe, 0);
    chk(tx_out_valid == 1'b0, "R10 tx_out_valid", tx_out_valid, 0);
    chk(rx_in_ready == 1'b1, "R10 rx_in_ready", rx_in_ready, 1);
    chk(flush == 1'b0, "R10 flush", flush, 0);
    chk(tx_overflow == 1'b0, "R10 tx_overflow", tx_overflow, 0);
    cyc(1);

    stat_chk(8'h02, "R4 idle status");
    suspend = 1'b1; cyc(2);
    stat_chk(8'h06, "R4 suspend bit");
    suspend = 1'b0; configured = 1'b1; cyc(2);
    stat_chk(8'h0A, "R4 configured bit");

    // R1: strobes without select
    f0 = flush_cnt;
    rd_n = 1'b0; cyc(6);
    @(negedge clk);
    chk(bus_oe == 1'b0, "R1 no drive deselected", bus_oe, 0);
    cyc(1); rd_n = 1'b1; cyc(3);
    bus_i = 8'h55; a0 = 1'b0; wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(4);
    a0 = 1'b1; wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(6);
    @(negedge clk);
    chk(tx_out_valid == 1'b0, "R1 no push deselected", tx_out_valid, 0);
    chk(flush_cnt == f0, "R1 no flush deselected", flush_cnt, f0);
    cyc(1);

    // receive path
    be_send(8'h11); be_send(8'h22); be_send(8'h33);
    stat_chk(8'h0B, "R4 rx available");
    stat_chk(8'h0B, "R4 status read does not pop");
    read_data_chk(6, "R3 first byte");
    read_data_chk(6, "R3 second byte");
    read_data_chk(40, "R7 long strobe");
    cpu_read(1'b0, 6, v, oe);
    chk(v == 8'h33, "R8 empty read repeats", v, 8'h33);
    cpu_read(1'b0, 6, v, oe);
    chk(v == 8'h33, "R8 empty read again", v, 8'h33);
    be_send(8'h44);
    read_data_chk(6, "R8 pointer unchanged");
    stat_chk(8'h0A, "R4 rx drained");

    be_send(8'h5A); be_send(8'hA5);
    read_data_chk(40, "R7 long strobe pops one");
    read_data_chk(6, "R7 next byte follows");

    // transmit path
    cpu_write(1'b0, 8'hC1, 1'b1);
    cpu_write(1'b0, 8'hC2, 1'b1);
    @(negedge clk);
    chk(tx_out_valid == 1'b1, "R5 valid after write", tx_out_valid, 1);
    chk(tx_out_data == 8'hC1, "R5 head byte", tx_out_data, 8'hC1);
    cyc(1); tx_out_ready = 1'b1; cyc(10);

    f0 = flush_cnt;
    cpu_write(1'b1, 8'h99, 1'b0);
    cyc(4);
    chk(flush_cnt == f0 + 1, "R6 one flush pulse", flush_cnt, f0 + 1);
    @(negedge clk);
    chk(tx_out_valid == 1'b0, "R6 nothing stored", tx_out_valid, 0);
    cyc(1);

    // overflow
    tx_out_ready = 1'b0;
    for (int i = 0; i <= DEPTH; i++) cpu_write(1'b0, DW'(i + 8'h60), i < DEPTH);
    @(negedge clk);
    chk(tx_overflow == 1'b1, "R9 overflow set", tx_overflow, 1);
    cyc(1);
    stat_chk(8'h08, "R4 tx full status");
    tx_out_ready = 1'b1; cyc(DEPTH + 20);
    @(negedge clk);
    chk(tx_overflow == 1'b1, "R9 overflow sticky", tx_overflow, 1);
    chk(exp_tx.size() == 0, "R5 all bytes delivered", exp_tx.size(), 0);
    cyc(1);

    // receive full
    for (int i = 0; i < DEPTH; i++) be_send(DW'(i + 8'h80));
    @(negedge clk);
    chk(rx_in_ready == 1'b0, "R11 ready low when full", rx_in_ready, 0);
    cyc(1);
    for (int i = 0; i < DEPTH; i++) read_data_chk(6, "R3 order after full");
    @(negedge clk);
    chk(rx_in_ready == 1'b1, "R11 ready after drain", rx_in_ready, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule